// File: doc/BRIEF.md
# Sector Buffer Program Controller

This block sequences sector programming for a word-wide nonvolatile memory. The storage cells are modelled as a register array. Words arrive on a valid/ready write stream. The first word accepted fixes the target sector, and later words for that sector fill a sector-sized buffer in any order. The load window stays open while words keep arriving. It closes after a run of quiet cycles, counted in clock cycles by a parameter.

When the window closes, the block enters a timed program period and raises `busy`. At the end of the period, the whole sector is replaced in one step. Words that were loaded keep their latest data, and every word that was not loaded becomes all ones. While the period runs, a read returns a status word instead of stored data, so software can poll for the end:
- Bits 15 and 7 are the complement of the last word accepted.
- Bits 14 and 6 flip on each read.

Back-pressure rules for the write stream:
- A word transfers on a cycle where `wr_valid` and `wr_ready` are both high.
- `wr_ready` is low for the whole program period.
- A source may hold `wr_valid` through that time. The held word is then taken once `wr_ready` returns, and it opens a new window.
- In the bench, a word offered while `wr_ready` is low is dropped by the source.
- The read port has no back-pressure. Each `rd_en` produces `rd_valid` with `rd_data` one cycle later.

Top module: `sector_prog_ctrl`

## Requirements
- R1: After reset, `busy` is low, `wr_ready` is high, and every address reads 16'hFFFF.
- R2: `wr_addr[ADDR_W-1:OFS_W]` is the sector and `wr_addr[OFS_W-1:0]` the word offset. The first accepted word fixes the window's sector. Later words of that sector are accepted in any order, and a repeated offset keeps the latest data.
- R3: The window closes at the end of the LOAD_TIMEOUT-th consecutive cycle with no accepted word, and `busy` is high from the next cycle. A word accepted on that LOAD_TIMEOUT-th cycle keeps the window open.
- R4: `busy` stays high for exactly PROG_CYCLES cycles. When it falls, the sector has been committed.
- R5: At commit, each loaded offset holds its latest data, each offset not loaded holds 16'hFFFF, and no other sector changes.
- R6: A word for a different sector than the window's is ignored. It changes no stored word.
- R7: While `busy` is high, `wr_ready` is low. Nothing offered in that time is stored, and nothing offered then opens a new window.
- R8: Outside the program period, `rd_en` gives `rd_valid` and the stored word at `rd_addr` on the next cycle.
- R9: A read taken while `busy` is high returns bit 15 = NOT of bit 15 of the last accepted word, and bit 7 = NOT of bit 7 of that word. Bits 13:8 and 5:0 are zero.
- R10: In status reads, bits 14 and 6 are equal. They are 0 on the first read of a program period and flip on every further read. After the period ends, repeated reads of one address return the same true data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Block can take a write word |
| wr_addr | input | ADDR_W | Write address (sector, offset) |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rd_valid | output | 1 | Read result valid (one cycle after `rd_en`) |
| rd_data | output | 16 | Stored word or status word |
| busy | output | 1 | Program period in progress |

## Verification
The assertions check the following on every cycle:
- the length of each `busy` pulse against PROG_CYCLES;
- the zero bits of status words and the equality of their two toggle bits;
- the alternation of the toggle bit across successive status reads.

Only the bench's scenarios can show the rest:
- the exact cycle on which a quiet window closes;
- that late-but-legal words keep the window open;
- the contents of a committed sector: latest data, all ones where not loaded, and other sectors untouched;
- that words for a foreign sector or words offered while busy leave no trace.

// File: rtl/spc_pkg.sv
package spc_pkg;
  localparam int WORD_W = 16;
  localparam logic [WORD_W-1:0] ERASED = '1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } spc_state_e;

  // Status word seen while programming: poll bits inverted, toggle bits equal.
  function automatic logic [WORD_W-1:0] status_word(logic [WORD_W-1:0] last, logic tog);
    logic [WORD_W-1:0] s;
    s      = '0;
    s[15]  = ~last[15];
    s[7]   = ~last[7];
    s[14]  = tog;
    s[6]   = tog;
    return s;
  endfunction
endpackage

// File: rtl/spc_window_ctrl.sv
module spc_window_ctrl
  import spc_pkg::*;
#(
  parameter int SEC_W        = 3,
  parameter int LOAD_TIMEOUT = 7500,
  parameter int PROG_CYCLES  = 500000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [SEC_W-1:0] wr_sec,
  output logic             wr_ready,
  output logic             load_en,
  output logic             close,
  output logic             commit,
  output logic             busy,
  output logic [SEC_W-1:0] sec_q
);
  localparam int TW = $clog2(LOAD_TIMEOUT + 1);
  localparam int PW = $clog2(PROG_CYCLES + 1);

  spc_state_e state;
  logic [TW-1:0] tmr;
  logic [PW-1:0] pcnt;
  logic          sec_match;

  assign wr_ready  = (state != ST_PROG);
  assign sec_match = (state == ST_IDLE) || (wr_sec == sec_q);
  assign load_en   = wr_valid && wr_ready && sec_match;
  assign close     = (state == ST_LOAD) && !load_en && (tmr == TW'(LOAD_TIMEOUT - 1));
  assign commit    = (state == ST_PROG) && (pcnt == PW'(PROG_CYCLES - 1));
  assign busy      = (state == ST_PROG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      tmr   <= '0;
      pcnt  <= '0;
      sec_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (load_en) begin
          sec_q <= wr_sec;
          tmr   <= '0;
          state <= ST_LOAD;
        end
        ST_LOAD: begin
          if (load_en)    tmr <= '0;
          else if (close) begin
            state <= ST_PROG;
            pcnt  <= '0;
          end else        tmr <= tmr + 1'b1;
        end
        ST_PROG: begin
          if (commit) state <= ST_IDLE;
          else        pcnt  <= pcnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spc_sector_buf.sv
module spc_sector_buf
  import spc_pkg::*;
#(
  parameter int OFS_W = 7
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              load_en,
  input  logic [OFS_W-1:0]                  wr_ofs,
  input  logic [WORD_W-1:0]                 wr_data,
  input  logic                              commit,
  output logic [(1<<OFS_W)-1:0][WORD_W-1:0] commit_words,
  output logic [WORD_W-1:0]                 last_q
);
  localparam int NW = 1 << OFS_W;

  logic [NW-1:0][WORD_W-1:0] buf_q;
  logic [NW-1:0]             loaded;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loaded <= '0;
      last_q <= '0;
    end else if (commit) begin
      loaded <= '0;
    end else if (load_en) begin
      buf_q[wr_ofs]  <= wr_data;
      loaded[wr_ofs] <= 1'b1;
      last_q         <= wr_data;
    end
  end

  for (genvar w = 0; w < NW; w++) begin : g_merge
    assign commit_words[w] = loaded[w] ? buf_q[w] : ERASED;
  end
endmodule

// File: rtl/spc_read_port.sv
module spc_read_port
  import spc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              busy,
  input  logic              close,
  input  logic [WORD_W-1:0] mem_word,
  input  logic [WORD_W-1:0] last_q,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data
);
  logic tog;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tog      <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (close)              tog <= 1'b0;
      else if (rd_en && busy) tog <= ~tog;
      if (rd_en) rd_data <= busy ? status_word(last_q, tog) : mem_word;
    end
  end
endmodule

// File: rtl/sector_prog_ctrl.sv
module sector_prog_ctrl
  import spc_pkg::*;
#(
  parameter int ADDR_W       = 10,
  parameter int OFS_W        = 7,
  parameter int LOAD_TIMEOUT = 7500,
  parameter int PROG_CYCLES  = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [15:0]       rd_data,
  output logic              busy
);
  localparam int SEC_W = ADDR_W - OFS_W;
  localparam int NW    = 1 << OFS_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic                      load_en, close, commit;
  logic [SEC_W-1:0]          sec_q;
  logic [NW-1:0][WORD_W-1:0] commit_words;
  logic [WORD_W-1:0]         last_q;
  logic [WORD_W-1:0]         mem [DEPTH];

  spc_window_ctrl #(
    .SEC_W(SEC_W), .LOAD_TIMEOUT(LOAD_TIMEOUT), .PROG_CYCLES(PROG_CYCLES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid),
    .wr_sec(wr_addr[ADDR_W-1:OFS_W]), .wr_ready(wr_ready),
    .load_en(load_en), .close(close), .commit(commit), .busy(busy), .sec_q(sec_q)
  );

  spc_sector_buf #(.OFS_W(OFS_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .wr_ofs(wr_addr[OFS_W-1:0]),
    .wr_data(wr_data), .commit(commit), .commit_words(commit_words), .last_q(last_q)
  );

  spc_read_port u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .busy(busy), .close(close),
    .mem_word(mem[rd_addr]), .last_q(last_q), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
    end else if (commit) begin
      for (int w = 0; w < NW; w++) mem[{sec_q, OFS_W'(w)}] <= commit_words[w];
    end
  end
endmodule

// File: rtl/spc_checker.sv
module spc_checker #(
  parameter int PROG_CYCLES = 500000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        rd_en,
  input logic        rd_valid,
  input logic [15:0] rd_data
);
  localparam int PW = $clog2(PROG_CYCLES + 2);
  logic [PW-1:0] bcnt;
  logic          stat_q, have_prev, prev_tog;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcnt <= '0; stat_q <= 1'b0; have_prev <= 1'b0; prev_tog <= 1'b0;
    end else begin
      bcnt   <= busy ? bcnt + 1'b1 : '0;
      stat_q <= rd_en && busy;
      if (rd_valid && stat_q) begin
        have_prev <= 1'b1;
        prev_tog  <= rd_data[6];
      end else if (!busy && !stat_q) begin
        have_prev <= 1'b0;
      end
    end
  end

  // R4
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> bcnt == PW'(PROG_CYCLES));

  // R9
  status_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && stat_q) |-> ((rd_data & 16'h3F3F) == 16'h0000));

  // R10
  toggle_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && stat_q) |-> rd_data[6] == rd_data[14]);

  // R10
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && stat_q && have_prev) |-> rd_data[6] != prev_tog);

  // R8
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
endmodule

bind sector_prog_ctrl spc_checker #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rd_en(rd_en),
  .rd_valid(rd_valid), .rd_data(rd_data)
);

// File: tb/sector_prog_ctrl_tb.sv
module sector_prog_ctrl_tb;
  localparam int ADDR_W = 10, OFS_W = 7, T = 8, P = 40;
  localparam int NW = 1 << OFS_W, DEPTH = 1 << ADDR_W;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, rd_en = 0;
  logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic wr_ready, rd_valid, busy;
  logic [15:0] rd_data;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [15:0] m_mem [DEPTH];
  logic [15:0] m_buf [NW];
  bit          m_ld  [NW];
  int          m_sec = -1;
  logic [15:0] m_last;

  always #10 clk = ~clk;

  sector_prog_ctrl #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .LOAD_TIMEOUT(T), .PROG_CYCLES(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy));

  task automatic chk(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_status(logic [15:0] last, bit t);
    return {~last[15], t, 6'b0, ~last[7], t, 6'b0};
  endfunction

  // Drive one write word for one cycle; updates the model as the requirements say.
  task automatic wr(int a, logic [15:0] d);
    bit rdy;
    rdy = wr_ready;
    wr_valid = 1; wr_addr = ADDR_W'(a); wr_data = d;
    @(negedge clk);
    wr_valid = 0;
    if (rdy && (m_sec < 0 || m_sec == (a >> OFS_W))) begin
      m_sec = a >> OFS_W;
      m_buf[a % NW] = d;
      m_ld[a % NW] = 1;
      m_last = d;
    end
  endtask

  task automatic rd(int a, output logic [15:0] d);
    rd_en = 1; rd_addr = ADDR_W'(a);
    @(negedge clk);
    rd_en = 0;
    chk(rd_valid === 1'b1, "R8 rd_valid", {15'b0, rd_valid}, 16'h1);
    d = rd_data;
  endtask

  function automatic void model_commit();
    for (int w = 0; w < NW; w++) begin
      m_mem[m_sec * NW + w] = m_ld[w] ? m_buf[w] : 16'hFFFF;
      m_ld[w] = 0;
    end
    m_sec = -1;
  endfunction

  task automatic wait_commit();
    int k = 0;
    while (!busy && k < T + 4) begin @(negedge clk); k++; end
    chk(busy === 1'b1, "R3 window closed", {15'b0, busy}, 16'h1);
    while (busy) @(negedge clk);
    model_commit();
  endtask

  task automatic verify_sector(int s, string req);
    logic [15:0] d;
    for (int w = 0; w < NW; w++) begin
      rd(s * NW + w, d);
      chk(d === m_mem[s * NW + w], req, d, m_mem[s * NW + w]);
    end
  endtask

  initial begin
    logic [15:0] d, d2;
    int n, s;
    void'($urandom(32'd4711));
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 16'hFFFF;
    for (int w = 0; w < NW; w++) m_ld[w] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(busy === 1'b0, "R1 busy", {15'b0, busy}, 16'h0);
    chk(wr_ready === 1'b1, "R1 wr_ready", {15'b0, wr_ready}, 16'h1);
    rd(0, d);          chk(d === 16'hFFFF, "R1 erased", d, 16'hFFFF);
    rd(DEPTH - 1, d);  chk(d === 16'hFFFF, "R1 erased", d, 16'hFFFF);

    // R2 R3 R5: out-of-order loads, duplicate offset, late-but-legal word
    wr(3 * NW + 5, 16'h1234);
    wr(3 * NW + 0, 16'hA5A5);
    wr(3 * NW + 5, 16'h4321);
    repeat (T - 1) @(negedge clk);
    chk(busy === 1'b0, "R3 still open before late word", {15'b0, busy}, 16'h0);
    wr(3 * NW + 127, 16'h8080);
    repeat (T - 1) @(negedge clk);
    chk(busy === 1'b0, "R3 open through T-1 quiet cycles", {15'b0, busy}, 16'h0);
    @(negedge clk);
    chk(busy === 1'b1, "R3 busy after T quiet cycles", {15'b0, busy}, 16'h1);
    n = 1;
    // R7 write while busy is refused
    chk(wr_ready === 1'b0, "R7 wr_ready low", {15'b0, wr_ready}, 16'h0);
    wr(3 * NW + 9, 16'h0F0F); if (busy) n++;
    // R9 R10 status reads
    for (int r = 0; r < 3; r++) begin
      rd(3 * NW + 127, d); if (busy) n++;
      chk(d === exp_status(m_last, r[0]), "R9 R10 status", d, exp_status(m_last, r[0]));
    end
    while (busy) begin @(negedge clk); if (busy) n++; end
    chk(n == P, "R4 busy length", 16'(n), 16'(P));
    model_commit();
    verify_sector(3, "R5 committed sector");
    rd(3 * NW + 5, d); rd(3 * NW + 5, d2);
    chk(d === d2 && d === 16'h4321, "R10 stable after end", d2, 16'h4321);
    repeat (2 * T) @(negedge clk);
    chk(busy === 1'b0, "R7 refused word opened no window", {15'b0, busy}, 16'h0);
    rd(3 * NW + 9, d); chk(d === 16'hFFFF, "R7 refused word not stored", d, 16'hFFFF);

    // R6 foreign sector ignored
    wr(5 * NW + 1, 16'h1111);
    wr(6 * NW + 1, 16'h6666);
    wr(5 * NW + 2, 16'h2222);
    wait_commit();
    verify_sector(5, "R6 window sector");
    rd(6 * NW + 1, d); chk(d === 16'hFFFF, "R6 foreign word ignored", d, 16'hFFFF);

    // Random sectors, offsets, data and gaps
    for (int it = 0; it < 6; it++) begin
      s = $urandom_range(0, (DEPTH / NW) - 1);
      n = $urandom_range(1, 12);
      for (int k = 0; k < n; k++) begin
        wr(s * NW + $urandom_range(0, NW - 1), 16'($urandom));
        repeat ($urandom_range(0, T - 1)) @(negedge clk);
      end
      wait_commit();
      verify_sector(s, "R2 R5 random sector");
      rd(((s + 1) % (DEPTH / NW)) * NW + 3, d);
      chk(d === m_mem[((s + 1) % (DEPTH / NW)) * NW + 3], "R5 other sector", d,
          m_mem[((s + 1) % (DEPTH / NW)) * NW + 3]);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule